// File: doc/BRIEF.md
# Lock-Aware Replacement Way Selector

This block decides which way of a set-associative cache set should receive the next filled block. It holds a valid bit and a recency ranking for every way of every set. For the set on its lookup port, it combines those with the per-way lock bits supplied by the tag side. From this it produces a one-hot victim vector. When every way is locked, it raises a flag instead of naming a way.

Any invalid way that is not locked is preferred over the replacement history. A fully empty set always yields way 0. Once no unlocked way is empty, the least recently used unlocked way is chosen. Locked ways are never offered.

Hits and completed fills move a way to the most recently used position of its set on the next clock edge. An invalidate port clears a valid bit without touching the history. The number of ways and of sets are parameters; they default to 2 ways and 4 sets.

Top module: `way_victim_picker`

## Requirements
- R1: When the looked-up set has at least one way that is both invalid and unlocked, `vic_way` names the lowest-numbered such way. Bit i of every way vector stands for way i.
- R2: When every way of the looked-up set is invalid and way 0 is unlocked, `vic_way` equals 1, which selects way 0.
- R3: When no unlocked way is invalid and at least one way is unlocked, `vic_way` names the unlocked way whose last hit or fill is oldest.
- R4: `vic_way` is one-hot or all zero, and it never has a bit set where `lk_lock` has a bit set.
- R5: `vic_none` is 1 exactly when every bit of `lk_lock` is set, and `vic_way` is 0 whenever `vic_none` is 1.
- R6: A hit makes the hit way the most recent way of its set from the next clock edge on. It leaves the recency of other sets unchanged and changes no valid bit.
- R7: A fill sets the valid bit of its way and makes that way the most recent of its set from the next edge on. An invalidate clears its valid bit and leaves recency unchanged. When a fill and an invalidate hit the same way of the same set in one cycle, the way ends up valid.
- R8: When a fill and a hit arrive in the same cycle, only the fill updates recency, and the hit is dropped.
- R9: A synchronous reset clears every valid bit and orders each set's recency so that way 0 is least recent, with recency rising with the way index. Right after reset every set reports `vic_way` = 1. Selection is combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_set | input | $clog2(NUM_SETS) | Set whose victim is being selected |
| lk_lock | input | NUM_WAYS | Lock bits of the looked-up set, bit i = way i |
| hit_en | input | 1 | A hit occurred this cycle |
| hit_set | input | $clog2(NUM_SETS) | Set of the hit |
| hit_way | input | NUM_WAYS | One-hot way of the hit |
| fill_en | input | 1 | A fill completed this cycle |
| fill_set | input | $clog2(NUM_SETS) | Set of the fill |
| fill_way | input | NUM_WAYS | One-hot way written by the fill |
| inv_en | input | 1 | Invalidate request this cycle |
| inv_set | input | $clog2(NUM_SETS) | Set of the invalidate |
| inv_way | input | NUM_WAYS | Ways to invalidate |
| lk_valid | output | NUM_WAYS | Valid bits of the looked-up set |
| vic_way | output | NUM_WAYS | One-hot victim way, zero when none |
| vic_none | output | 1 | No way may be replaced |

## Verification
The bench runs a four-way, four-set instance through all 256 combinations of valid pattern and lock pattern in one set. It also sweeps every lock pattern on an empty set. A selector that let a locked way win, or that fell back to recency while an empty unlocked way existed, would name the wrong way. One that pinned an empty set to way 0 even when way 0 is locked would also fail. Pseudo-random hit streams across sets then test the history: a design that updated the wrong set, or ranked among locked ways, would name a way that is not the oldest unlocked one. Same-cycle fill/hit and fill/invalidate pairs catch a design that lets the hit reorder history or lets the invalidate win. A mid-run reset must return every set to an empty state that reports way 0.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

   // Upper bound on ways supported by the shared helpers.
   localparam int unsigned VSEL_MAX_WAYS = 16;

   // Index of the lowest set bit; 0 when the vector is empty.
   function automatic int unsigned low_idx(input logic [VSEL_MAX_WAYS-1:0] v);
      int unsigned r;
      r = 0;
      for (int i = VSEL_MAX_WAYS - 1; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/vsel_valid_store.sv
module vsel_valid_store
   import vsel_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 2,
   parameter int unsigned NUM_SETS = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        fill_en,
   input  logic [$clog2(NUM_SETS)-1:0] fill_set,
   input  logic [NUM_WAYS-1:0]         fill_way,
   input  logic                        inv_en,
   input  logic [$clog2(NUM_SETS)-1:0] inv_set,
   input  logic [NUM_WAYS-1:0]         inv_way,
   input  logic [$clog2(NUM_SETS)-1:0] rd_set,
   output logic [NUM_WAYS-1:0]         rd_valid
);

   localparam int unsigned SW = $clog2(NUM_SETS);

   logic [NUM_WAYS-1:0] vbits_q [NUM_SETS];

   // Clear first, then set: a fill beats an invalidate on the same bit.
   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_SETS; s++) vbits_q[s] <= '0;
      end else begin
         for (int s = 0; s < NUM_SETS; s++) begin
            vbits_q[s] <= (vbits_q[s]
                           & ~((inv_en && (inv_set == SW'(s))) ? inv_way : '0))
                          | ((fill_en && (fill_set == SW'(s))) ? fill_way : '0);
         end
      end
   end

   assign rd_valid = vbits_q[rd_set];

endmodule

// File: rtl/vsel_recency_store.sv
module vsel_recency_store
   import vsel_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 2,
   parameter int unsigned NUM_SETS = 4
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  upd_en,
   input  logic [$clog2(NUM_SETS)-1:0]           upd_set,
   input  logic [NUM_WAYS-1:0]                   upd_way,
   input  logic [$clog2(NUM_SETS)-1:0]           rd_set,
   output logic [NUM_WAYS*$clog2(NUM_WAYS)-1:0]  rd_age
);

   localparam int unsigned AW = $clog2(NUM_WAYS);

   // Age 0 = most recent, NUM_WAYS-1 = least recent; ages form a permutation.
   logic [AW-1:0] age_q [NUM_SETS][NUM_WAYS];
   logic [AW-1:0] tgt_idx;
   logic [AW-1:0] tgt_age;

   always_comb begin
      tgt_idx = AW'(low_idx(VSEL_MAX_WAYS'(upd_way)));
      tgt_age = age_q[upd_set][tgt_idx];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
               age_q[s][w] <= AW'(NUM_WAYS - 1 - w);
            end
         end
      end else if (upd_en) begin
         for (int w = 0; w < NUM_WAYS; w++) begin
            if (AW'(w) == tgt_idx) begin
               age_q[upd_set][w] <= '0;
            end else if (age_q[upd_set][w] < tgt_age) begin
               age_q[upd_set][w] <= age_q[upd_set][w] + AW'(1);
            end
         end
      end
   end

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
      assign rd_age[w*AW +: AW] = age_q[rd_set][w];
   end

endmodule

// File: rtl/vsel_pick.sv
module vsel_pick
   import vsel_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 2
) (
   input  logic [NUM_WAYS-1:0]                  valid,
   input  logic [NUM_WAYS-1:0]                  lock,
   input  logic [NUM_WAYS*$clog2(NUM_WAYS)-1:0] age,
   output logic [NUM_WAYS-1:0]                  victim,
   output logic                                 none
);

   localparam int unsigned AW = $clog2(NUM_WAYS);

   logic [NUM_WAYS-1:0] empty_open;
   logic [NUM_WAYS-1:0] open_ways;
   logic [NUM_WAYS-1:0] empty_pick;
   logic [NUM_WAYS-1:0] lru_pick;

   assign empty_open = ~valid & ~lock;
   assign open_ways  = ~lock;

   always_comb begin
      empty_pick = '0;
      empty_pick[low_idx(VSEL_MAX_WAYS'(empty_open))] = |empty_open;
   end

   if (NUM_WAYS == 2) begin : g_lru_two
      // Two ways: the older way wins unless it is locked.
      always_comb begin
         lru_pick = '0;
         if (&open_ways) lru_pick = (age[0 +: AW] != '0) ? 2'b01 : 2'b10;
         else            lru_pick = open_ways;
      end
   end else begin : g_lru_many
      logic [AW-1:0] best_age;
      logic          found;
      always_comb begin
         lru_pick = '0;
         best_age = '0;
         found    = 1'b0;
         for (int w = 0; w < NUM_WAYS; w++) begin
            if (open_ways[w] && (!found || age[w*AW +: AW] > best_age)) begin
               lru_pick    = '0;
               lru_pick[w] = 1'b1;
               best_age    = age[w*AW +: AW];
               found       = 1'b1;
            end
         end
      end
   end

   always_comb begin
      none = ~|open_ways;
      if (|empty_open)    victim = empty_pick;
      else if (|open_ways) victim = lru_pick;
      else                victim = '0;
   end

endmodule

// File: rtl/way_victim_picker.sv
module way_victim_picker
   import vsel_pkg::*;
#(
   parameter int unsigned NUM_WAYS = 2,
   parameter int unsigned NUM_SETS = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [$clog2(NUM_SETS)-1:0] lk_set,
   input  logic [NUM_WAYS-1:0]         lk_lock,
   input  logic                        hit_en,
   input  logic [$clog2(NUM_SETS)-1:0] hit_set,
   input  logic [NUM_WAYS-1:0]         hit_way,
   input  logic                        fill_en,
   input  logic [$clog2(NUM_SETS)-1:0] fill_set,
   input  logic [NUM_WAYS-1:0]         fill_way,
   input  logic                        inv_en,
   input  logic [$clog2(NUM_SETS)-1:0] inv_set,
   input  logic [NUM_WAYS-1:0]         inv_way,
   output logic [NUM_WAYS-1:0]         lk_valid,
   output logic [NUM_WAYS-1:0]         vic_way,
   output logic                        vic_none
);

   localparam int unsigned SW = $clog2(NUM_SETS);
   localparam int unsigned AW = $clog2(NUM_WAYS);

   if (NUM_WAYS < 2 || NUM_WAYS > VSEL_MAX_WAYS) begin : g_bad_ways
      $error("way_victim_picker: NUM_WAYS out of range");
   end
   if (NUM_SETS < 2 || NUM_SETS != (1 << SW)) begin : g_bad_sets
      $error("way_victim_picker: NUM_SETS must be a power of two >= 2");
   end

   logic                 upd_en;
   logic [SW-1:0]        upd_set;
   logic [NUM_WAYS-1:0]  upd_way;
   logic [NUM_WAYS*AW-1:0] lk_age;

   // One recency update per cycle; a fill takes precedence over a hit.
   assign upd_en  = fill_en | hit_en;
   assign upd_set = fill_en ? fill_set : hit_set;
   assign upd_way = fill_en ? fill_way : hit_way;

   vsel_valid_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_valid (
      .clk      (clk),
      .rst      (rst),
      .fill_en  (fill_en),
      .fill_set (fill_set),
      .fill_way (fill_way),
      .inv_en   (inv_en),
      .inv_set  (inv_set),
      .inv_way  (inv_way),
      .rd_set   (lk_set),
      .rd_valid (lk_valid)
   );

   vsel_recency_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_recency (
      .clk     (clk),
      .rst     (rst),
      .upd_en  (upd_en),
      .upd_set (upd_set),
      .upd_way (upd_way),
      .rd_set  (lk_set),
      .rd_age  (lk_age)
   );

   vsel_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
      .valid  (lk_valid),
      .lock   (lk_lock),
      .age    (lk_age),
      .victim (vic_way),
      .none   (vic_none)
   );

endmodule

// File: rtl/vsel_checker.sv
module vsel_checker #(
   parameter int unsigned NUM_WAYS = 2,
   parameter int unsigned NUM_SETS = 4
) (
   input logic                        clk,
   input logic                        rst,
   input logic [$clog2(NUM_SETS)-1:0] lk_set,
   input logic [NUM_WAYS-1:0]         lk_lock,
   input logic                        fill_en,
   input logic [$clog2(NUM_SETS)-1:0] fill_set,
   input logic [NUM_WAYS-1:0]         fill_way,
   input logic [NUM_WAYS-1:0]         lk_valid,
   input logic [NUM_WAYS-1:0]         vic_way,
   input logic                        vic_none
);

   assert_invalid_first_R1: assert property (@(posedge clk) disable iff (rst)
      (|(~lk_valid & ~lk_lock)) |-> (|(vic_way & ~lk_valid)));

   assert_empty_set_way0_R2: assert property (@(posedge clk) disable iff (rst)
      (lk_valid == '0 && !lk_lock[0]) |-> (vic_way == NUM_WAYS'(1)));

   assert_victim_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(vic_way));

   assert_no_locked_victim_R4: assert property (@(posedge clk) disable iff (rst)
      (vic_way & lk_lock) == '0);

   assert_none_iff_all_locked_R5: assert property (@(posedge clk) disable iff (rst)
      vic_none == (&lk_lock));

   assert_none_no_way_R5: assert property (@(posedge clk) disable iff (rst)
      vic_none |-> (vic_way == '0));

   assert_fill_sets_valid_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(fill_en) && !$past(rst) && $past(fill_set) == lk_set)
      |-> ((lk_valid & $past(fill_way)) == $past(fill_way)));

   assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lk_valid == '0));

endmodule

bind way_victim_picker vsel_checker #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_vsel_checker (
   .clk      (clk),
   .rst      (rst),
   .lk_set   (lk_set),
   .lk_lock  (lk_lock),
   .fill_en  (fill_en),
   .fill_set (fill_set),
   .fill_way (fill_way),
   .lk_valid (lk_valid),
   .vic_way  (vic_way),
   .vic_none (vic_none)
);

// File: tb/way_victim_picker_bench.sv
module way_victim_picker_bench;

   localparam int unsigned NW = 4;
   localparam int unsigned NS = 4;
   localparam int unsigned SW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [SW-1:0] lk_set = '0;
   logic [NW-1:0] lk_lock = '0;
   logic          hit_en = 1'b0;
   logic [SW-1:0] hit_set = '0;
   logic [NW-1:0] hit_way = '0;
   logic          fill_en = 1'b0;
   logic [SW-1:0] fill_set = '0;
   logic [NW-1:0] fill_way = '0;
   logic          inv_en = 1'b0;
   logic [SW-1:0] inv_set = '0;
   logic [NW-1:0] inv_way = '0;
   logic [NW-1:0] lk_valid;
   logic [NW-1:0] vic_way;
   logic          vic_none;

   way_victim_picker #(.NUM_WAYS(NW), .NUM_SETS(NS)) u_way_victim_picker (
      .clk(clk), .rst(rst), .lk_set(lk_set), .lk_lock(lk_lock),
      .hit_en(hit_en), .hit_set(hit_set), .hit_way(hit_way),
      .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
      .inv_en(inv_en), .inv_set(inv_set), .inv_way(inv_way),
      .lk_valid(lk_valid), .vic_way(vic_way), .vic_none(vic_none)
   );

   always #4 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // Reference model: valid bits and last-use stamps (smaller = older).
   bit mv [NS][NW];
   int ts [NS][NW];
   int tick = 0;
   int unsigned seed = 32'h1234_5678;

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 16;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            mv[s][w] = 1'b0;
            ts[s][w] = w - 100;
         end
   endtask

   task automatic apply_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      model_reset();
   endtask

   // One cycle of stimulus; model follows the stated rules.
   task automatic op(input bit fe, input int fs, input int fw,
                     input bit he, input int hs, input int hw,
                     input bit ie, input int is, input int iw);
      @(negedge clk);
      fill_en = fe; fill_set = SW'(fs); fill_way = NW'(1) << fw;
      hit_en  = he; hit_set  = SW'(hs); hit_way  = NW'(1) << hw;
      inv_en  = ie; inv_set  = SW'(is); inv_way  = NW'(1) << iw;
      @(negedge clk);
      fill_en = 1'b0; hit_en = 1'b0; inv_en = 1'b0;
      if (ie) mv[is][iw] = 1'b0;
      if (fe) begin mv[fs][fw] = 1'b1; tick++; ts[fs][fw] = tick; end
      else if (he) begin tick++; ts[hs][hw] = tick; end
   endtask

   task automatic check_pick(input int s, input int lock, input string why);
      logic [NW-1:0] exp_way;
      bit            exp_none;
      bit            any_empty;
      bit            all_empty;
      string         tag;
      int            best;
      exp_way = '0; any_empty = 1'b0; all_empty = 1'b1; best = -1;
      for (int w = 0; w < NW; w++) if (mv[s][w]) all_empty = 1'b0;
      for (int w = NW - 1; w >= 0; w--)
         if (!mv[s][w] && !lock[w]) begin any_empty = 1'b1; exp_way = NW'(1) << w; end
      if (!any_empty)
         for (int w = 0; w < NW; w++)
            if (!lock[w] && (best < 0 || ts[s][w] < ts[s][best])) best = w;
      if (!any_empty && best >= 0) exp_way = NW'(1) << best;
      exp_none = (lock == (1 << NW) - 1);
      if (exp_none) tag = "R5";
      else if (all_empty && !lock[0]) tag = "R2";
      else if (any_empty) tag = "R1";
      else tag = "R3";
      lk_set = SW'(s); lk_lock = NW'(lock);
      #1;
      total++;
      if (vic_way !== exp_way || vic_none !== exp_none) begin
         bad++;
         $display("FAIL %s (%s) set=%0d lock=%b: way=%b none=%b expected way=%b none=%b",
                  tag, why, s, lock[NW-1:0], vic_way, vic_none, exp_way, exp_none);
      end
      total++;
      if ((vic_way & NW'(lock)) != '0) begin   // R4
         bad++;
         $display("FAIL R4 set=%0d lock=%b: way=%b expected no locked way",
                  s, lock[NW-1:0], vic_way);
      end
   endtask

   task automatic check_valid(input int s, input string tag);
      logic [NW-1:0] exp_v;
      for (int w = 0; w < NW; w++) exp_v[w] = mv[s][w];
      lk_set = SW'(s);
      #1;
      total++;
      if (lk_valid !== exp_v) begin
         bad++;
         $display("FAIL %s set=%0d: valid=%b expected=%b", tag, s, lk_valid, exp_v);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      apply_reset();

      // R9: reset state of every set
      for (int s = 0; s < NS; s++) begin
         check_valid(s, "R9");
         check_pick(s, 0, "R9 after reset");
      end

      // R2, R1, R5: empty set under every lock pattern
      for (int l = 0; l < 16; l++) check_pick(0, l, "empty set");

      // R1, R3, R4, R5, R7: every valid pattern x every lock pattern in set 1
      for (int v = 0; v < 16; v++) begin
         for (int w = 0; w < NW; w++) begin
            if (v[w]) op(1, 1, w, 0, 0, 0, 0, 0, 0);
            else      op(0, 0, 0, 0, 0, 0, 1, 1, w);
         end
         check_valid(1, "R7");
         for (int l = 0; l < 16; l++) check_pick(1, l, "valid sweep");
      end

      // R6: hit streams across sets with random locks
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) op(1, s, w, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 120; i++) begin
         op(0, 0, 0, 1, rnd() % NS, rnd() % NW, 0, 0, 0);
         check_pick(2, rnd() % 16, "R6 hit stream");
         check_pick(3, 0, "R6 hit stream");
         check_valid(2, "R6");
      end

      // R8: fill and hit in the same cycle
      for (int a = 0; a < NW; a++)
         for (int b = 0; b < NW; b++) begin
            if (a == b) continue;
            op(1, 2, a, 1, 2, b, 0, 0, 0);
            check_pick(2, 0, "R8 fill+hit");
            check_pick(2, 1 << a, "R8 fill+hit");
         end

      // R7: fill and invalidate on the same way in one cycle
      for (int w = 0; w < NW; w++) begin
         op(1, 3, w, 0, 0, 0, 1, 3, w);
         check_valid(3, "R7 fill beats invalidate");
         op(0, 0, 0, 0, 0, 0, 1, 3, w);
         check_valid(3, "R7 invalidate");
         check_pick(3, 0, "R7 invalidate");
         op(1, 3, w, 0, 0, 0, 0, 0, 0);
      end

      // R9: mid-run reset
      apply_reset();
      for (int s = 0; s < NS; s++) begin
         check_valid(s, "R9");
         check_pick(s, 0, "R9 mid-run reset");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule